// File: doc/BRIEF.md
# Serial Flash Programmed-I/O Register Front End

This block is the software-facing register layer of a half-duplex serial flash master that moves data by programmed I/O. A simple 32-bit register bus reaches the controller configuration, the transfer setup, two data FIFOs and an interrupt unit. Software sets the lane mode and direction first. It then writes a byte count, which launches the transfer on the serial engine, a separate block. The engine drains the transmit FIFO one byte at a time, or fills the receive FIFO one byte at a time. Software refills or empties these FIFOs when an interrupt arrives.

Transmit data enters either through a single-byte port or through a four-byte port whose low byte goes first. Receive data leaves through a read port that pops up to four bytes per access, with the oldest byte in the low lane. Progress and error events collect in one status word. Each status bit is cleared by writing a one to it. Status is masked by an enable word, and the result drives a single level-high interrupt line.

Top module: `sfl_pio_front`

## Requirements
- R1: Out of reset, all writable registers, the status word and both FIFOs are zero or empty. `irq_o` and `eng_start_o` are low. Offset 0x1C reads `TX_DEPTH << 16` and offset 0x2C reads 0x800.
- R2: Offset 0x00 is a full 32-bit read/write word driven on `mst_cfg_o`. Offset 0x18 keeps only bit 0 (direction, 1 = write), bits 3:1 (lane mode) and bit 8 (fragment); these drive `eng_dir_o`, `eng_mode_o` and `eng_frag_o`, and the other bits read zero.
- R3: A write to offset 0x14 stores bits 15:0 as the byte count. The count reads back and appears on `eng_count_o`, and `eng_start_o` goes high for exactly the one cycle after the write.
- R4: A write to 0x20 pushes bits 7:0 into the transmit FIFO. A write to 0x24 pushes four bytes, bits 7:0 first. The engine sees the bytes in push order on `tx_data_o` while `tx_valid_o` is high and consumes one with `tx_pop_i`. Offset 0x1C bits 31:16 give the free bytes, `TX_DEPTH` minus the occupancy.
- R5: A push that does not fit in the free space is dropped whole and sets status bit 11.
- R6: A read of offset 0x50 pops min(occupancy, 4) receive bytes, returned with the oldest in bits 7:0 and zero in the lanes that hold no byte. A byte offered on `rx_push_i` while the receive FIFO is full is dropped.
- R7: A read of offset 0x50 with the receive FIFO empty returns zero and sets status bit 0.
- R8: Offset 0x2C reads as follows: bit 11 is empty, bits 10:4 are the occupancy, and bits 1, 2 and 3 are set when the occupancy is at least 16, 32 and 64. Bit 0 is ready: at least 4 bytes, or any bytes once no transfer is in flight. A transfer is in flight from the count write until `eng_done_i`.
- R9: Writing 1 in bit 0 of offset 0x30 empties the receive FIFO at the next edge.
- R10: Status at 0x10 is set by events and conditions and cleared by writing ones. If a set and a clear meet in the same cycle, the set wins. The condition bits are bit 1 (receive FIFO not empty), bit 2 (receive ready), bit 9 (transmit FIFO empty) and bit 10 (transmit FIFO full). They set again while their condition holds.
- R11: Offset 0x0C keeps only bits 0-3, 9-11 and 16. `irq_o` is high exactly when some status bit and its enable are both set.
- R12: `eng_done_i` sets status bit 16 and ends the in-flight transfer. `bus_err_i` sets status bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops at 0x50) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Level-high interrupt |
| mst_cfg_o | output | 32 | Controller configuration word |
| eng_start_o | output | 1 | One-cycle transfer launch |
| eng_count_o | output | 16 | Transfer byte count |
| eng_dir_o | output | 1 | Direction, 1 = write |
| eng_mode_o | output | 3 | Lane mode |
| eng_frag_o | output | 1 | Fragment flag |
| eng_done_i | input | 1 | Byte count exhausted |
| bus_err_i | input | 1 | Bus error response |
| tx_data_o | output | 8 | Head byte of the transmit FIFO |
| tx_valid_o | output | 1 | Transmit FIFO not empty |
| tx_pop_i | input | 1 | Engine consumes the head byte |
| rx_data_i | input | 8 | Received byte |
| rx_push_i | input | 1 | Engine delivers a byte |

## Verification
A pointer or occupancy that slips by one shows up within one access. It appears as a wrong free-space or occupancy field at 0x1C or 0x2C, or as a misordered byte on `tx_data_o` or in the packed word from 0x50. A status bit that fails to set or clear shows on `irq_o` in the cycle after the event, once its enable is on. The bench fills and drains both FIFOs through every occupancy, with the byte values derived from their position. This makes order, packing, thresholds and the boundaries at full and empty all visible at the ports.

// File: rtl/sfl_pio_pkg.sv
package sfl_pio_pkg;
  localparam logic [7:0] OFF_MCFG  = 8'h00;
  localparam logic [7:0] OFF_IEN   = 8'h0C;
  localparam logic [7:0] OFF_IST   = 8'h10;
  localparam logic [7:0] OFF_XCTL  = 8'h14;
  localparam logic [7:0] OFF_XCFG  = 8'h18;
  localparam logic [7:0] OFF_XST   = 8'h1C;
  localparam logic [7:0] OFF_DB    = 8'h20;
  localparam logic [7:0] OFF_DW    = 8'h24;
  localparam logic [7:0] OFF_RST   = 8'h2C;
  localparam logic [7:0] OFF_RRST  = 8'h30;
  localparam logic [7:0] OFF_RDAT  = 8'h50;

  localparam int BIT_UNR  = 0;
  localparam int BIT_RNE  = 1;
  localparam int BIT_RRDY = 2;
  localparam int BIT_BERR = 3;
  localparam int BIT_TEMP = 9;
  localparam int BIT_TFUL = 10;
  localparam int BIT_OVR  = 11;
  localparam int BIT_DONE = 16;

  localparam logic [31:0] IRQ_MASK = 32'h0001_0E0F;
  localparam logic [31:0] XCFG_MASK = 32'h0000_010F;
endpackage

// File: rtl/sfl_byte_fifo.sv
module sfl_byte_fifo #(
  parameter int unsigned DEPTH = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           flush_i,
  input  logic [2:0]                     push_n_i,
  input  logic [31:0]                    push_data_i,
  input  logic [2:0]                     pop_n_i,
  output logic [31:0]                    head_o,
  output logic [$clog2(DEPTH+1)-1:0]     cnt_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [7:0]    mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] wr_idx [4];
  logic [AW-1:0] rd_idx [4];

  for (genvar k = 0; k < 4; k++) begin : g_lane
    assign wr_idx[k] = wptr_q + AW'(k);
    assign rd_idx[k] = rptr_q + AW'(k);
    assign head_o[8*k +: 8] = (CW'(k) < cnt_q) ? mem_q[rd_idx[k]] : 8'h00;
  end

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < 4; k++)
      if (k < int'(push_n_i)) mem_q[wr_idx[k]] <= push_data_i[8*k +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_q + AW'(push_n_i);
      rptr_q <= rptr_q + AW'(pop_n_i);
      cnt_q  <= cnt_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= int'(DEPTH)); // R5
  AST_POP_WITHIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_n_i) <= int'(cnt_q)); // R7
  AST_PUSH_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(push_n_i) + int'(cnt_q) <= int'(DEPTH) + int'(pop_n_i)); // R5
endmodule

// File: rtl/sfl_irq.sv
module sfl_irq
  import sfl_pio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] set_i,
  input  logic        clr_we_i,
  input  logic        en_we_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] st_o,
  output logic [31:0] en_o,
  output logic        irq_o
);
  logic [31:0] st_q, en_q, clr;

  assign clr = clr_we_i ? wdata_i : 32'h0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= ((st_q & ~clr) | set_i) & IRQ_MASK;
      if (en_we_i) en_q <= wdata_i & IRQ_MASK;
    end
  end

  assign st_o  = st_q;
  assign en_o  = en_q;
  assign irq_o = |(st_q & en_q);

  AST_DONE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[BIT_DONE] |=> st_q[BIT_DONE]); // R12
  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && wdata_i[BIT_DONE] && !set_i[BIT_DONE]) |=> !st_q[BIT_DONE]); // R10
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && set_i[BIT_BERR]) |=> st_q[BIT_BERR]); // R10
endmodule

// File: rtl/sfl_pio_front.sv
module sfl_pio_front
  import sfl_pio_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned TX_DEPTH = 16,
  parameter int unsigned RX_DEPTH = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              irq_o,
  output logic [31:0]       mst_cfg_o,
  output logic              eng_start_o,
  output logic [15:0]       eng_count_o,
  output logic              eng_dir_o,
  output logic [2:0]        eng_mode_o,
  output logic              eng_frag_o,
  input  logic              eng_done_i,
  input  logic              bus_err_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_pop_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_push_i
);
  localparam int unsigned TX_CW = $clog2(TX_DEPTH+1);
  localparam int unsigned RX_CW = $clog2(RX_DEPTH+1);

  logic we_cfg, we_ien, we_ist, we_ctl, we_xcfg, we_db, we_dw, we_rrst, re_rx;
  assign we_cfg  = reg_we_i && reg_addr_i == ADDR_W'(OFF_MCFG);
  assign we_ien  = reg_we_i && reg_addr_i == ADDR_W'(OFF_IEN);
  assign we_ist  = reg_we_i && reg_addr_i == ADDR_W'(OFF_IST);
  assign we_ctl  = reg_we_i && reg_addr_i == ADDR_W'(OFF_XCTL);
  assign we_xcfg = reg_we_i && reg_addr_i == ADDR_W'(OFF_XCFG);
  assign we_db   = reg_we_i && reg_addr_i == ADDR_W'(OFF_DB);
  assign we_dw   = reg_we_i && reg_addr_i == ADDR_W'(OFF_DW);
  assign we_rrst = reg_we_i && reg_addr_i == ADDR_W'(OFF_RRST) && reg_wdata_i[0];
  assign re_rx   = reg_re_i && reg_addr_i == ADDR_W'(OFF_RDAT);

  // configuration and launch
  logic [31:0] cfg_q;
  logic [8:0]  xcfg_q;
  logic [15:0] count_q;
  logic        start_q, busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      xcfg_q  <= '0;
      count_q <= '0;
      start_q <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      if (we_cfg)  cfg_q  <= reg_wdata_i;
      if (we_xcfg) xcfg_q <= reg_wdata_i[8:0] & XCFG_MASK[8:0];
      if (we_ctl)  count_q <= reg_wdata_i[15:0];
      start_q <= we_ctl;
      if (we_ctl)          busy_q <= 1'b1;
      else if (eng_done_i) busy_q <= 1'b0;
    end
  end

  assign mst_cfg_o   = cfg_q;
  assign eng_start_o = start_q;
  assign eng_count_o = count_q;
  assign eng_dir_o   = xcfg_q[0];
  assign eng_mode_o  = xcfg_q[3:1];
  assign eng_frag_o  = xcfg_q[8];

  // transmit path
  logic [TX_CW-1:0] tx_cnt, tx_free;
  logic [31:0]      tx_head, tx_wdata;
  logic [2:0]       tx_push_n, tx_pop_n;
  logic             tx_ovr;

  assign tx_free = TX_CW'(TX_DEPTH) - tx_cnt;
  always_comb begin
    tx_push_n = 3'd0;
    tx_ovr    = 1'b0;
    tx_wdata  = reg_wdata_i;
    if (we_db) begin
      tx_wdata = {24'h0, reg_wdata_i[7:0]};
      if (tx_free != '0) tx_push_n = 3'd1;
      else               tx_ovr    = 1'b1;
    end else if (we_dw) begin
      if (int'(tx_free) >= 4) tx_push_n = 3'd4;
      else                    tx_ovr    = 1'b1;
    end
  end
  assign tx_pop_n = (tx_pop_i && tx_cnt != '0) ? 3'd1 : 3'd0;

  sfl_byte_fifo #(.DEPTH(TX_DEPTH)) u_txf (
    .clk_i, .rst_ni, .flush_i(1'b0),
    .push_n_i(tx_push_n), .push_data_i(tx_wdata), .pop_n_i(tx_pop_n),
    .head_o(tx_head), .cnt_o(tx_cnt)
  );

  logic unused_tx_head;
  assign unused_tx_head = ^tx_head[31:8];
  assign tx_data_o  = tx_head[7:0];
  assign tx_valid_o = tx_cnt != '0;

  // receive path
  logic [RX_CW-1:0] rx_cnt;
  logic [31:0]      rx_head;
  logic [2:0]       rx_push_n, rx_pop_n;
  logic             rx_unr, rx_rdy;

  assign rx_push_n = (rx_push_i && int'(rx_cnt) < int'(RX_DEPTH)) ? 3'd1 : 3'd0;
  assign rx_pop_n  = !re_rx ? 3'd0 : (int'(rx_cnt) >= 4) ? 3'd4 : rx_cnt[2:0];
  assign rx_unr    = re_rx && rx_cnt == '0;
  assign rx_rdy    = int'(rx_cnt) >= 4 || (rx_cnt != '0 && !busy_q);

  sfl_byte_fifo #(.DEPTH(RX_DEPTH)) u_rxf (
    .clk_i, .rst_ni, .flush_i(we_rrst),
    .push_n_i(rx_push_n), .push_data_i({24'h0, rx_data_i}), .pop_n_i(rx_pop_n),
    .head_o(rx_head), .cnt_o(rx_cnt)
  );

  logic [31:0] rx_stat;
  assign rx_stat = {20'h0, rx_cnt == '0, 7'(rx_cnt), int'(rx_cnt) >= 64,
                    int'(rx_cnt) >= 32, int'(rx_cnt) >= 16, rx_rdy};

  // interrupt unit
  logic [31:0] st_set, st_w, en_w;
  always_comb begin
    st_set = '0;
    st_set[BIT_UNR]  = rx_unr;
    st_set[BIT_RNE]  = rx_cnt != '0;
    st_set[BIT_RRDY] = rx_rdy;
    st_set[BIT_BERR] = bus_err_i;
    st_set[BIT_TEMP] = tx_cnt == '0;
    st_set[BIT_TFUL] = int'(tx_cnt) == int'(TX_DEPTH);
    st_set[BIT_OVR]  = tx_ovr;
    st_set[BIT_DONE] = eng_done_i;
  end

  sfl_irq u_irq (
    .clk_i, .rst_ni, .set_i(st_set), .clr_we_i(we_ist), .en_we_i(we_ien),
    .wdata_i(reg_wdata_i), .st_o(st_w), .en_o(en_w), .irq_o
  );

  // read mux
  always_comb begin
    case (reg_addr_i)
      ADDR_W'(OFF_MCFG): reg_rdata_o = cfg_q;
      ADDR_W'(OFF_IEN):  reg_rdata_o = en_w;
      ADDR_W'(OFF_IST):  reg_rdata_o = st_w;
      ADDR_W'(OFF_XCTL): reg_rdata_o = {16'h0, count_q};
      ADDR_W'(OFF_XCFG): reg_rdata_o = {23'h0, xcfg_q};
      ADDR_W'(OFF_XST):  reg_rdata_o = {16'(tx_free), 16'h0};
      ADDR_W'(OFF_RST):  reg_rdata_o = rx_stat;
      ADDR_W'(OFF_RDAT): reg_rdata_o = rx_head;
      default:           reg_rdata_o = 32'h0;
    endcase
  end

  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_ctl |=> (eng_start_o && eng_count_o == $past(reg_wdata_i[15:0]))); // R3
  AST_START_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_start_o && !$past(we_ctl)) |-> 1'b0 == eng_start_o); // R3
  AST_OVR_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_db && tx_free == '0) |=> st_w[BIT_OVR]); // R5
  AST_UNDERRUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_rx && rx_cnt == '0) |=> st_w[BIT_UNR]); // R7
  AST_RX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_rrst |=> rx_cnt == '0); // R9
endmodule

// File: tb/sim_sfl_pio_front.sv
`timescale 1ns/1ps
module sim_sfl_pio_front;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = '0;
  logic we = 0, re = 0, done = 0, berr = 0, tpop = 0, rpush = 0;
  logic [31:0] wdata = '0, rdata, mcfg;
  logic [7:0] rbyte = '0, tdata;
  logic irq, start, dir, frag, tvalid;
  logic [15:0] cnt;
  logic [2:0] mode;
  int vectors = 0, errs = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sfl_pio_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_we_i(we), .reg_re_i(re),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .mst_cfg_o(mcfg),
    .eng_start_o(start), .eng_count_o(cnt), .eng_dir_o(dir), .eng_mode_o(mode),
    .eng_frag_o(frag), .eng_done_i(done), .bus_err_i(berr), .tx_data_o(tdata),
    .tx_valid_o(tvalid), .tx_pop_i(tpop), .rx_data_i(rbyte), .rx_push_i(rpush)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1; #1 d = rdata;
    @(negedge clk); re = 0;
  endtask

  task automatic tx_take(output logic [7:0] b, output logic v);
    @(negedge clk); b = tdata; v = tvalid; tpop = 1;
    @(negedge clk); tpop = 0;
  endtask

  task automatic rx_give(input logic [7:0] b);
    @(negedge clk); rbyte = b; rpush = 1;
    @(negedge clk); rpush = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
  endtask

  function automatic logic [31:0] rx_exp(input int n, input bit busy);
    logic [31:0] r;
    r = 32'(n) << 4;
    r[11] = (n == 0);
    r[3]  = (n >= 64);
    r[2]  = (n >= 32);
    r[1]  = (n >= 16);
    r[0]  = (n >= 4) || (n != 0 && !busy);
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      vectors++; errs++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [7:0] b;
    logic v;
    repeat (3) @(negedge clk);
    addr = 8'h10; #1;
    check("R1 status in reset", rdata, 32'h0);
    check("R1 irq in reset", {31'h0, irq}, 32'h0);
    check("R1 start in reset", {31'h0, start}, 32'h0);
    rst_n = 1;
    rd(8'h1C, d); check("R1 tx free", d, 32'h0010_0000);
    rd(8'h2C, d); check("R1 rx status", d, 32'h800);
    rd(8'h00, d); check("R1 mcfg", d, 32'h0);

    wr(8'h00, 32'hDEAD_BEEF);
    rd(8'h00, d); check("R2 mcfg readback", d, 32'hDEAD_BEEF);
    check("R2 mcfg port", mcfg, 32'hDEAD_BEEF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, d); check("R2 xcfg mask", d, 32'h10F);
    check("R2 xcfg ports", {27'h0, frag, mode, dir}, {27'h0, 1'b1, 3'd7, 1'b1});
    wr(8'h18, 32'h0000_0006);
    check("R2 xcfg ports 2", {27'h0, frag, mode, dir}, {27'h0, 1'b0, 3'd3, 1'b0});

    wr(8'h14, 32'hABCD_1234);
    check("R3 start high", {31'h0, start}, 32'h1);
    check("R3 count port", {16'h0, cnt}, 32'h1234);
    @(negedge clk);
    check("R3 start one cycle", {31'h0, start}, 32'h0);
    rd(8'h14, d); check("R3 count readback", d, 32'h1234);

    // byte port sweep
    for (int n = 1; n <= 16; n++) begin
      wr(8'h20, 32'hFFFF_FF00 | 32'((n * 7 + 3) & 8'hFF));
      rd(8'h1C, d); check("R4 free after byte push", d, 32'(16 - n) << 16);
    end
    rd(8'h10, d); check("R10 tx full bit", {31'h0, d[10]}, 32'h1);
    wr(8'h20, 32'h55);
    rd(8'h10, d); check("R5 overrun on byte", {31'h0, d[11]}, 32'h1);
    rd(8'h1C, d); check("R5 free unchanged", d, 32'h0);
    for (int i = 1; i <= 16; i++) begin
      tx_take(b, v);
      check("R4 byte order", {23'h0, v, b}, {23'h0, 1'b1, 8'((i * 7 + 3) & 8'hFF)});
    end
    check("R4 tx empty valid", {31'h0, tvalid}, 32'h0);
    wr(8'h10, 32'h800);
    rd(8'h10, d); check("R10 w1c overrun", {31'h0, d[11]}, 32'h0);

    // word port
    for (int j = 0; j < 4; j++) begin
      wr(8'h24, 32'h0302_0100 + 32'(j) * 32'h0404_0404);
      rd(8'h1C, d); check("R4 free after word push", d, 32'(12 - 4 * j) << 16);
    end
    wr(8'h24, 32'h1111_1111);
    rd(8'h10, d); check("R5 overrun on word", {31'h0, d[11]}, 32'h1);
    for (int i = 0; i < 16; i++) begin
      tx_take(b, v);
      check("R4 word byte order", {24'h0, b}, 32'(i));
    end
    wr(8'h10, 32'h800);
    for (int j = 0; j < 3; j++) wr(8'h24, 32'h0302_0100 + 32'(j) * 32'h0404_0404);
    wr(8'h20, 32'hA0); wr(8'h20, 32'hA1);
    rd(8'h1C, d); check("R4 free 2", d, 32'h0002_0000);
    wr(8'h24, 32'h9999_9999);
    rd(8'h1C, d); check("R5 partial word dropped", d, 32'h0002_0000);
    rd(8'h10, d); check("R5 partial word overrun", {31'h0, d[11]}, 32'h1);
    wr(8'h20, 32'hA2);
    rd(8'h1C, d); check("R4 free 1", d, 32'h0001_0000);
    for (int i = 0; i < 15; i++) begin
      tx_take(b, v);
      check("R4 mixed order", {24'h0, b}, (i < 12) ? 32'(i) : 32'(8'hA0 + i - 12));
    end

    // receive sweep, transfer in flight
    for (int n = 1; n <= 64; n++) begin
      rx_give(8'(8'h40 + n - 1));
      rd(8'h2C, d); check("R8 rx status busy", d, rx_exp(n, 1));
    end
    rx_give(8'hFF);
    rd(8'h2C, d); check("R6 full drops push", d, rx_exp(64, 1));
    for (int i = 0; i < 16; i++) begin
      rd(8'h50, d);
      check("R6 packed pop", d, {8'(8'h43 + 4 * i), 8'(8'h42 + 4 * i),
                                 8'(8'h41 + 4 * i), 8'(8'h40 + 4 * i)});
    end
    rd(8'h2C, d); check("R6 drained", d, 32'h800);

    rx_give(8'h11); rx_give(8'h22); rx_give(8'h33);
    rd(8'h2C, d); check("R8 three bytes busy", d, rx_exp(3, 1));
    pulse_done();
    rd(8'h2C, d); check("R8 three bytes idle", d, rx_exp(3, 0));
    rd(8'h10, d); check("R12 done bit", {31'h0, d[16]}, 32'h1);
    rd(8'h50, d); check("R6 short pop", d, 32'h0033_2211);
    rd(8'h50, d); check("R7 empty pop zero", d, 32'h0);
    rd(8'h10, d); check("R7 underrun bit", {31'h0, d[0]}, 32'h1);

    for (int i = 0; i < 10; i++) rx_give(8'(i));
    rd(8'h2C, d); check("R8 ten idle", d, rx_exp(10, 0));
    wr(8'h30, 32'h1);
    rd(8'h2C, d); check("R9 flush", d, 32'h800);

    // interrupts
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); check("R10 level bit survives clear", d, 32'h200);
    wr(8'h0C, 32'h0001_0000);
    check("R11 irq masked", {31'h0, irq}, 32'h0);
    pulse_done();
    check("R11 irq on done", {31'h0, irq}, 32'h1);
    wr(8'h10, 32'h0001_0000);
    check("R11 irq after w1c", {31'h0, irq}, 32'h0);
    wr(8'h0C, 32'h0000_0200);
    check("R11 irq on tx empty", {31'h0, irq}, 32'h1);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, d); check("R11 enable mask", d, 32'h0001_0E0F);
    @(negedge clk); berr = 1;
    @(negedge clk); berr = 0;
    rd(8'h10, d); check("R12 bus error bit", {31'h0, d[3]}, 32'h1);
    wr(8'h0C, 32'h0);
    check("R11 irq all masked", {31'h0, irq}, 32'h0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule